// File: doc/BRIEF.md
# Monitor Self-Test Pattern Generator

This block lets a display show a picture when no external source is connected. From a 12 MHz clock it produces its own horizontal sync, vertical sync and a one-bit video level. The video carries one of four fixed images: a light grid on a dark field, a dark grid on a light field, solid white or solid black. Three line rates are available, and the frame rate stays near 60 Hz at each of them. Control inputs choose the image and the line rate, and an enable input turns the whole output on or off.

The image choice and the enable act on the next clock. The line rate is held in an internal copy that is updated only when a frame wraps back to its first pixel. Because of this, switching rates never produces a cut-short line or frame. All three outputs come from flip-flops, one clock after the counter state they describe.

Top module: `test_pattern_gen`

## Requirements
- R1: While `rst` is high, `hsync_n` and `vsync_n` are 1 and `video` is 0. Release of reset starts the frame at line 0, column 0, using the rate code present during reset.
- R2: The rate code sets the line length: 0 gives `P_FAST` clocks, 1 gives `P_MID`, and 2 or 3 give `P_SLOW`. `hsync_n` is 0 during the first floor(P*8/100) clocks of each line.
- R3: The rate code sets the frame length: 0 gives `L_FAST` lines, 1 gives `L_MID`, and 2 or 3 give `L_SLOW`. `vsync_n` is 0 during the first `VS_LINES` lines of each frame.
- R4: A change of `rate_sel` in the middle of a frame has no effect on line or frame length until the next frame begins.
- R5: The image code on `pat_sel` is 0 for light grid, 1 for dark grid, 2 for solid white and 3 for solid black. A change takes effect on the next clock.
- R6: Light grid: `video` is 1 inside the active region when column bits [GRID_LOG2-1:0] are zero or line bits [GRID_LOG2-1:0] are zero, and 0 everywhere else. The active region is column c with 2*hs <= c < P-hs, together with line l with 2*VS_LINES <= l < L-VS_LINES. Here hs is the sync width from R2.
- R7: Dark grid: inside the active region `video` is the inverse of the light grid. Outside the active region it is 0.
- R8: Solid white gives 1 across the whole active region and 0 outside it. Solid black gives 0 everywhere.
- R9: With `out_en` low, `hsync_n` and `vsync_n` are 1 and `video` is 0. The counters keep running, so turning the output back on resumes the timing already in progress.
- R10: Every output is registered. The value seen after a clock edge reflects the counters, `pat_sel` and `out_en` as they were at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rst | input | 1 | Synchronous reset, active high |
| out_en | input | 1 | 1 drives the outputs, 0 holds them inactive |
| pat_sel | input | 2 | Image code (R5) |
| rate_sel | input | 2 | Line-rate code (R2, R3) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | 1 | One-bit video level |

## Verification
The hardest case to bring about is a rate change in the middle of a frame. The old rate has to hold for many hundreds of clocks, and the new one has to appear exactly at the wrap. The stimulus changes `rate_sel` partway through a frame and then runs across the frame boundary, including a change to code 3. A reference model keyed to its own frame counters predicts every output cycle, so a length that switches early or late shows up on the first sync edge that lands in the wrong place. The bench shrinks the line and frame lengths so that many frames fit in the run.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    PAT_GRID_LIGHT = 2'd0,
    PAT_GRID_DARK  = 2'd1,
    PAT_WHITE      = 2'd2,
    PAT_BLACK      = 2'd3
  } pat_e;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2,
    RATE_ALT  = 2'd3
  } rate_e;
endpackage

// File: rtl/tpg_timing.sv
module tpg_timing #(
  parameter int P_FAST = 189,
  parameter int P_MID  = 252,
  parameter int P_SLOW = 378,
  parameter int L_FAST = 1058,
  parameter int L_MID  = 793,
  parameter int L_SLOW = 529,
  parameter int HW     = 9,
  parameter int VW     = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rate_sel,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic [HW-1:0] line_len,
  output logic [HW-1:0] hs_len,
  output logic [VW-1:0] frame_len
);
  import tpg_pkg::*;

  localparam int HS_FAST = (P_FAST * 8) / 100;
  localparam int HS_MID  = (P_MID * 8) / 100;
  localparam int HS_SLOW = (P_SLOW * 8) / 100;

  rate_e rate_q;
  logic  line_end, frame_end;

  always_comb begin
    case (rate_q)
      RATE_FAST: begin
        line_len  = HW'(P_FAST);
        hs_len    = HW'(HS_FAST);
        frame_len = VW'(L_FAST);
      end
      RATE_MID: begin
        line_len  = HW'(P_MID);
        hs_len    = HW'(HS_MID);
        frame_len = VW'(L_MID);
      end
      default: begin
        line_len  = HW'(P_SLOW);
        hs_len    = HW'(HS_SLOW);
        frame_len = VW'(L_SLOW);
      end
    endcase
  end

  assign line_end  = (h_cnt == line_len - HW'(1));
  assign frame_end = line_end && (v_cnt == frame_len - VW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt  <= '0;
      v_cnt  <= '0;
      rate_q <= rate_e'(rate_sel);
    end else if (line_end) begin
      h_cnt <= '0;
      if (frame_end) begin
        v_cnt  <= '0;
        rate_q <= rate_e'(rate_sel);
      end else begin
        v_cnt <= v_cnt + VW'(1);
      end
    end else begin
      h_cnt <= h_cnt + HW'(1);
    end
  end

  // R2: inside a line the column advances by exactly one per clock
  a_r2_column_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(line_end)) |-> (h_cnt == $past(h_cnt) + HW'(1)));

  // R3: the line counter changes only when a line wraps
  a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(line_end)) |-> $stable(v_cnt));

  // R4: the active rate changes only at a frame start
  a_r4_rate_at_frame: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(h_cnt == '0 && v_cnt == '0)) |-> $stable(rate_q));
endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern #(
  parameter int HW        = 9,
  parameter int VW        = 11,
  parameter int VS_LINES  = 3,
  parameter int GRID_LOG2 = 4
) (
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic [HW-1:0] line_len,
  input  logic [HW-1:0] hs_len,
  input  logic [VW-1:0] frame_len,
  input  logic [1:0]    pat_sel,
  output logic          pix
);
  import tpg_pkg::*;

  logic [HW:0] h_lo, h_hi;
  logic        in_h, in_v, active, on_grid;

  assign h_lo   = {hs_len, 1'b0};
  assign h_hi   = {1'b0, line_len} - {1'b0, hs_len};
  assign in_h   = ({1'b0, h_cnt} >= h_lo) && ({1'b0, h_cnt} < h_hi);
  assign in_v   = (v_cnt >= VW'(2 * VS_LINES)) && (v_cnt < frame_len - VW'(VS_LINES));
  assign active = in_h && in_v;

  assign on_grid = (h_cnt[GRID_LOG2-1:0] == '0) || (v_cnt[GRID_LOG2-1:0] == '0);

  always_comb begin
    case (pat_e'(pat_sel))
      PAT_GRID_LIGHT: pix = active && on_grid;
      PAT_GRID_DARK:  pix = active && !on_grid;
      PAT_WHITE:      pix = active;
      default:        pix = 1'b0;
    endcase
  end
endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
  parameter int P_FAST    = 189,
  parameter int P_MID     = 252,
  parameter int P_SLOW    = 378,
  parameter int L_FAST    = 1058,
  parameter int L_MID     = 793,
  parameter int L_SLOW    = 529,
  parameter int VS_LINES  = 3,
  parameter int GRID_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       out_en,
  input  logic [1:0] pat_sel,
  input  logic [1:0] rate_sel,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       video
);
  localparam int P_MAX = (P_FAST > P_MID) ? ((P_FAST > P_SLOW) ? P_FAST : P_SLOW)
                                          : ((P_MID > P_SLOW) ? P_MID : P_SLOW);
  localparam int L_MAX = (L_FAST > L_MID) ? ((L_FAST > L_SLOW) ? L_FAST : L_SLOW)
                                          : ((L_MID > L_SLOW) ? L_MID : L_SLOW);
  localparam int HW = $clog2(P_MAX + 1);
  localparam int VW = $clog2(L_MAX + 1);

  logic [HW-1:0] h_cnt, line_len, hs_len;
  logic [VW-1:0] v_cnt, frame_len;
  logic          pix;

  tpg_timing #(
    .P_FAST(P_FAST), .P_MID(P_MID), .P_SLOW(P_SLOW),
    .L_FAST(L_FAST), .L_MID(L_MID), .L_SLOW(L_SLOW),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .h_cnt(h_cnt), .v_cnt(v_cnt),
    .line_len(line_len), .hs_len(hs_len), .frame_len(frame_len)
  );

  tpg_pattern #(
    .HW(HW), .VW(VW), .VS_LINES(VS_LINES), .GRID_LOG2(GRID_LOG2)
  ) u_pattern (
    .h_cnt(h_cnt), .v_cnt(v_cnt),
    .line_len(line_len), .hs_len(hs_len), .frame_len(frame_len),
    .pat_sel(pat_sel), .pix(pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      video   <= 1'b0;
    end else begin
      hsync_n <= !(out_en && (h_cnt < hs_len));
      vsync_n <= !(out_en && (v_cnt < VW'(VS_LINES)));
      video   <= out_en && pix;
    end
  end

  // R9: a disabled cycle leaves every output inactive
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(out_en)) |-> (hsync_n && vsync_n && !video));

  // R8: solid black never lights the video
  a_r8_black_dark: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pat_sel) == 2'd3) |-> !video);

  // R3: vertical sync is only active in the first lines of a frame
  a_r3_vsync_window: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !vsync_n) |-> ($past(v_cnt) < VW'(VS_LINES)));

  // R2: horizontal sync never coincides with lit video
  a_r2_hsync_blank: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> !video);
endmodule

// File: tb/test_pattern_gen_tb.sv
module test_pattern_gen_tb;
  localparam int PF = 25, PM = 32, PS = 50;
  localparam int LF = 40, LM = 30, LS = 20;
  localparam int VS = 3, G = 4;

  typedef struct {
    logic       hs;
    logic       vs;
    logic       vid;
    logic       en;
    logic [1:0] pat;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic out_en = 1'b1;
  logic [1:0] pat_sel = 2'd0;
  logic [1:0] rate_sel = 2'd0;
  logic hsync_n, vsync_n, video;

  int checks = 0;
  int fails = 0;
  string phase = "";
  exp_t q[$];

  always #5 clk = ~clk;

  test_pattern_gen #(
    .P_FAST(PF), .P_MID(PM), .P_SLOW(PS),
    .L_FAST(LF), .L_MID(LM), .L_SLOW(LS),
    .VS_LINES(VS), .GRID_LOG2(G)
  ) u_dut (
    .clk(clk), .rst(rst), .out_en(out_en), .pat_sel(pat_sel),
    .rate_sel(rate_sel), .hsync_n(hsync_n), .vsync_n(vsync_n), .video(video)
  );

  function automatic int per_of(int r);
    return (r == 0) ? PF : (r == 1) ? PM : PS;
  endfunction
  function automatic int lines_of(int r);
    return (r == 0) ? LF : (r == 1) ? LM : LS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model (R1-R10): own frame counters, one-clock output latency (R10)
  int eh = 0, ev = 0, er = 0;
  always @(posedge clk) begin
    exp_t e;
    if (rst) begin
      eh = 0; ev = 0; er = int'(rate_sel);
      e = '{hs: 1'b1, vs: 1'b1, vid: 1'b0, en: 1'b0, pat: 2'd0};
    end else begin
      int p, l, hs;
      bit act, grid, pix;
      p = per_of(er); l = lines_of(er); hs = (p * 8) / 100;
      act  = (eh >= 2 * hs) && (eh < p - hs) && (ev >= 2 * VS) && (ev < l - VS);
      grid = ((eh % (1 << G)) == 0) || ((ev % (1 << G)) == 0);
      case (pat_sel)
        2'd0: pix = act && grid;
        2'd1: pix = act && !grid;
        2'd2: pix = act;
        default: pix = 1'b0;
      endcase
      e.en  = out_en;
      e.pat = pat_sel;
      e.hs  = !(out_en && (eh < hs));
      e.vs  = !(out_en && (ev < VS));
      e.vid = out_en && pix;
      if (eh == p - 1) begin
        eh = 0;
        if (ev == l - 1) begin ev = 0; er = int'(rate_sel); end
        else ev++;
      end else eh++;
    end
    q.push_back(e);
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string ts, tv;
      e = q.pop_front();
      if (!e.en) begin ts = "R9"; tv = "R9"; end
      else begin
        ts = (phase != "") ? phase : "R2";
        tv = (e.pat == 2'd0) ? "R6" : (e.pat == 2'd1) ? "R7" : "R8";
      end
      check(hsync_n == e.hs, {ts, " hsync"}, hsync_n, e.hs);
      check(vsync_n == e.vs, {(ts == "R2") ? "R3" : ts, " vsync"}, vsync_n, e.vs);
      check(video == e.vid, {tv, " video"}, video, e.vid);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    run(4);
    // R1: reset state
    check(hsync_n == 1'b1 && vsync_n == 1'b1 && video == 1'b0, "R1 reset", video, 0);
    rst = 1'b0;
    // R5/R6: light grid at the fast rate over two frames
    run(2 * PF * LF);
    // R7: dark grid, switched mid-frame
    pat_sel = 2'd1; run(PF * LF + 137);
    // R8: solid white, then solid black
    pat_sel = 2'd2; run(PF * LF);
    pat_sel = 2'd3; run(PF * LF);
    // R4: rate change in mid-frame; old timing holds to the frame end
    pat_sel = 2'd0; phase = "R4";
    rate_sel = 2'd1; run(PF * LF + 3 * PM * LM);
    rate_sel = 2'd2; run(PM * LM + 2 * PS * LS);
    // R2: code 3 behaves as the slow rate
    rate_sel = 2'd3; pat_sel = 2'd1; run(3 * PS * LS);
    phase = "";
    // R9: disabled output while timing runs, then resumed
    out_en = 1'b0; run(PS * LS + 77);
    out_en = 1'b1; pat_sel = 2'd2; run(2 * PS * LS);
    rate_sel = 2'd0; pat_sel = 2'd0; run(PS * LS + 2 * PF * LF);
    // R1: reset in mid-frame restarts with the present rate code
    rst = 1'b1; rate_sel = 2'd1; run(3);
    check(hsync_n == 1'b1 && vsync_n == 1'b1 && video == 1'b0, "R1 mid reset", video, 0);
    rst = 1'b0; run(2 * PM * LM);
    run(2);
    finish_run();
  end
endmodule